// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block draws a 16x16 hardware cursor on top of a scan-out stream of 8-bit palette indices. Each pixel arrives with its signed x and y screen coordinate. One clock later the block returns either the original index or a cursor colour index. The cursor image is held in two bitmap planes of sixteen 16-bit words each. For every cursor pixel, the pair of plane bits selects transparent, background colour (index 254) or foreground colour (index 255). Palette lookup and frame-buffer storage happen elsewhere.

The cursor position is written in an encoded form. A negated two's-complement field is combined with fixed bias terms and, for X only, a low field that is not negated. The block decodes these writes into signed 13-bit screen coordinates. Cursor columns that fall outside the visible width pass the frame-buffer index through unchanged, so the cursor can sit partly off either edge.

A small state machine tracks whether the cursor has moved or changed visibility since the last frame start. It has two states:
- `ST_SYNCED`: nothing has changed since the last frame start.
- `ST_PENDING`: a position or control write has arrived since then.

The machine leaves `ST_SYNCED` for `ST_PENDING` on any write to the X, Y or control register. It returns to `ST_SYNCED` on a frame-start pulse, unless a position or control write lands in the same cycle. While the machine is in `ST_PENDING`, a queried line that crosses the old or the new cursor row span is reported as needing a refresh.

Top module: `cursor_overlay`

## Requirements
- R1: A write of value v to address 32 sets the cursor X to −sext12(v & 0xFFC) + (v & 3) − 232, computed as a 13-bit signed value. Bits 15:12 of v are ignored.
- R2: A write of value v to address 33 sets the cursor Y to −sext12(v & 0xFFF) − 15, computed as a 13-bit signed value. Bits 15:12 of v are ignored.
- R3: Plane A word r sits at address r and plane B word r at address 16+r, for r in 0..15. At a covered pixel, bits A=1 and B=1 give out_idx 255. Exactly one bit set gives 254. Both bits clear pass pix_idx through.
- R4: The pixel at (X+c, Y+r), for c and r in 0..15, uses bit c of word r in each plane. Bit 0 is the leftmost column and word 0 is the top row. Pixels outside that 16x16 square pass through.
- R5: Bit 0 of address 34 is the visibility enable. While it is 0, every pixel passes through unchanged.
- R6: A pixel with x < 0 or x ≥ SCREEN_W passes through unchanged. Cursor columns that remain on screen are still drawn when part of the cursor is off screen.
- R7: out_valid equals pix_valid delayed by one clock. out_idx belongs to the pixel presented one clock earlier.
- R8: A configuration write strobed in one cycle already governs a pixel presented in the next cycle.
- R9: After a write to address 32, 33 or 34, line_dirty is 1 for query_y inside [Y, Y+15] when the cursor is visible. It is also 1 inside the span recorded at the last frame_start when the cursor was visible then. It is 0 elsewhere.
- R10: A frame_start pulse with no position or control write in the same cycle records the current Y and visibility. After it, line_dirty is 0 for every line until the next write to address 32, 33 or 34.
- R11: After reset, out_valid and line_dirty are 0, the cursor is hidden, and all plane words are zero.
- R12: Writes to addresses 35 and above change neither the drawn cursor nor line_dirty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (6) | Write address: planes 0..31, X 32, Y 33, control 34 |
| cfg_data | input | 16 | Write data |
| frame_start | input | 1 | Pulse at the start of a frame; records the shown cursor |
| pix_valid | input | 1 | Incoming pixel valid |
| pix_x | input | 13 | Signed pixel column |
| pix_y | input | 13 | Signed pixel row |
| pix_idx | input | 8 | Frame-buffer palette index |
| out_valid | output | 1 | Output pixel valid |
| out_idx | output | 8 | Palette index after the overlay |
| query_y | input | 13 | Signed line number to test for refresh |
| line_dirty | output | 1 | The queried line crosses a changed cursor span |

## Verification
A wrong decoded position, or a plane word stored at the wrong row, shows up on the first scan line that crosses the true or the false cursor square. It appears as 254 or 255 in the wrong columns, one clock after the affected pixel enters. A clipping fault appears only at pixels on or beyond the screen edges, so the sweeps cover columns from −3 to SCREEN_W+2. A stale or wrong refresh state appears on line_dirty as soon as the next line is queried after a write or a frame start.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    localparam int COORD_W = 13;

    typedef logic signed [COORD_W-1:0] coord_t;

    localparam logic [7:0] IDX_FG = 8'hFF;
    localparam logic [7:0] IDX_BG = 8'hFE;

    typedef enum logic [0:0] {
        ST_SYNCED  = 1'b0,
        ST_PENDING = 1'b1
    } sync_state_t;

    // Coarse field [11:2] is negated as a 12-bit two's-complement value;
    // the low two bits are added without negation.
    function automatic coord_t decode_x(input logic [15:0] raw, input coord_t bias);
        coord_t coarse;
        coord_t fine;
        coarse = {raw[11], raw[11:2], 2'b00};
        fine   = {11'd0, raw[1:0]};
        return coord_t'(-coarse + fine - bias);
    endfunction

    function automatic coord_t decode_y(input logic [15:0] raw, input coord_t bias);
        coord_t whole;
        whole = {raw[11], raw[11:0]};
        return coord_t'(-whole - bias);
    endfunction

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int CUR_DIM = 16,
    parameter int ADDR_W  = 6,
    parameter int X_BIAS  = 232,
    parameter int Y_BIAS  = 15
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [15:0]                      cfg_data,
    output logic [CUR_DIM-1:0][CUR_DIM-1:0]  plane_a,
    output logic [CUR_DIM-1:0][CUR_DIM-1:0]  plane_b,
    output coord_t                           cur_x,
    output coord_t                           cur_y,
    output logic                             cur_vis,
    output logic                             pos_wr
);

    localparam int IDX_W     = $clog2(CUR_DIM);
    localparam int ADDR_X    = 2 * CUR_DIM;
    localparam int ADDR_Y    = ADDR_X + 1;
    localparam int ADDR_CTRL = ADDR_X + 2;
    localparam int NPLANES   = 2;

    logic hit_x;
    logic hit_y;
    logic hit_ctrl;

    always_comb begin
        hit_x    = cfg_we && (cfg_addr == ADDR_W'(ADDR_X));
        hit_y    = cfg_we && (cfg_addr == ADDR_W'(ADDR_Y));
        hit_ctrl = cfg_we && (cfg_addr == ADDR_W'(ADDR_CTRL));
        pos_wr   = hit_x || hit_y || hit_ctrl;
    end

    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        logic [CUR_DIM-1:0][CUR_DIM-1:0] words;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words <= '0;
            end else if (cfg_we &&
                         (cfg_addr[ADDR_W-1:IDX_W] == (ADDR_W-IDX_W)'(p))) begin
                words[cfg_addr[IDX_W-1:0]] <= cfg_data[CUR_DIM-1:0];
            end
        end
    end

    assign plane_a = g_plane[0].words;
    assign plane_b = g_plane[1].words;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x   <= decode_x(16'd0, coord_t'(X_BIAS));
            cur_y   <= decode_y(16'd0, coord_t'(Y_BIAS));
            cur_vis <= 1'b0;
        end else begin
            if (hit_x)    cur_x   <= decode_x(cfg_data, coord_t'(X_BIAS));
            if (hit_y)    cur_y   <= decode_y(cfg_data, coord_t'(Y_BIAS));
            if (hit_ctrl) cur_vis <= cfg_data[0];
        end
    end

    // R12: writes above the control address leave position and visibility untouched
    a_r12_unused_addr_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (cfg_addr > ADDR_W'(ADDR_CTRL)))
            |=> ($stable(cur_x) && $stable(cur_y) && $stable(cur_vis)));

    // R9: a position/control strobe never coincides with a write into plane storage
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        pos_wr |-> (cfg_addr >= ADDR_W'(ADDR_X)));

endmodule

// File: rtl/cursor_pixel.sv
module cursor_pixel
    import cursor_pkg::*;
#(
    parameter int SCREEN_W = 1024,
    parameter int CUR_DIM  = 16,
    parameter int PIX_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pix_valid,
    input  coord_t                           pix_x,
    input  coord_t                           pix_y,
    input  logic [PIX_W-1:0]                 pix_idx,
    input  coord_t                           cur_x,
    input  coord_t                           cur_y,
    input  logic                             cur_vis,
    input  logic [CUR_DIM-1:0][CUR_DIM-1:0]  plane_a,
    input  logic [CUR_DIM-1:0][CUR_DIM-1:0]  plane_b,
    output logic                             out_valid,
    output logic [PIX_W-1:0]                 out_idx
);

    localparam int IDX_W = $clog2(CUR_DIM);
    localparam logic signed [COORD_W:0] DIM_S  = (COORD_W+1)'(CUR_DIM);
    localparam logic signed [COORD_W:0] ZERO_S = '0;
    localparam coord_t                  SCR_W  = coord_t'(SCREEN_W);
    localparam coord_t                  SCR_0  = '0;

    logic signed [COORD_W:0] dx;
    logic signed [COORD_W:0] dy;
    logic                    on_screen;
    logic                    in_square;
    logic [IDX_W-1:0]        col;
    logic [IDX_W-1:0]        row;
    logic                    bit_a;
    logic                    bit_b;
    logic [PIX_W-1:0]        next_idx;

    always_comb begin
        dx        = {pix_x[COORD_W-1], pix_x} - {cur_x[COORD_W-1], cur_x};
        dy        = {pix_y[COORD_W-1], pix_y} - {cur_y[COORD_W-1], cur_y};
        on_screen = (pix_x >= SCR_0) && (pix_x < SCR_W);
        in_square = (dx >= ZERO_S) && (dx < DIM_S) && (dy >= ZERO_S) && (dy < DIM_S);
        col       = dx[IDX_W-1:0];
        row       = dy[IDX_W-1:0];
        bit_a     = plane_a[row][col];
        bit_b     = plane_b[row][col];
        next_idx  = pix_idx;
        if (cur_vis && on_screen && in_square) begin
            unique case ({bit_a, bit_b})
                2'b11:        next_idx = PIX_W'(IDX_FG);
                2'b10, 2'b01: next_idx = PIX_W'(IDX_BG);
                default:      next_idx = pix_idx;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
        end else begin
            out_valid <= pix_valid;
            out_idx   <= next_idx;
        end
    end

    // R7: one-cycle valid pipeline
    a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    a_r7_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    // R3: any substitution yields one of the two cursor colours
    a_r3_colour_only: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid ##1 (out_idx != $past(pix_idx))
            |-> (out_idx == PIX_W'(IDX_FG) || out_idx == PIX_W'(IDX_BG)));

    // R5: hidden cursor is transparent
    a_r5_hidden_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cur_vis) |=> (out_idx == $past(pix_idx)));

    // R6: off-screen columns pass through
    a_r6_offscreen_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ((pix_x < SCR_0) || (pix_x >= SCR_W)))
            |=> (out_idx == $past(pix_idx)));

endmodule

// File: rtl/cursor_refresh.sv
module cursor_refresh
    import cursor_pkg::*;
#(
    parameter int CUR_DIM = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pos_wr,
    input  logic   frame_start,
    input  coord_t cur_y,
    input  logic   cur_vis,
    input  coord_t query_y,
    output logic   line_dirty
);

    localparam logic signed [COORD_W:0] DIM_S  = (COORD_W+1)'(CUR_DIM);
    localparam logic signed [COORD_W:0] ZERO_S = '0;

    sync_state_t state;
    sync_state_t state_nx;
    coord_t      shown_y;
    logic        shown_vis;

    function automatic logic row_in_span(input coord_t q, input coord_t base);
        logic signed [COORD_W:0] d;
        d = {q[COORD_W-1], q} - {base[COORD_W-1], base};
        return (d >= ZERO_S) && (d < DIM_S);
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_SYNCED;
            shown_y   <= '0;
            shown_vis <= 1'b0;
        end else begin
            state <= state_nx;
            if (frame_start) begin
                shown_y   <= cur_y;
                shown_vis <= cur_vis;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SYNCED:  if (pos_wr) state_nx = ST_PENDING;
            ST_PENDING: if (frame_start && !pos_wr) state_nx = ST_SYNCED;
            default:    state_nx = ST_SYNCED;
        endcase
    end

    // outputs
    always_comb begin
        line_dirty = 1'b0;
        unique case (state)
            ST_SYNCED:  line_dirty = 1'b0;
            ST_PENDING: line_dirty = (cur_vis && row_in_span(query_y, cur_y)) ||
                                     (shown_vis && row_in_span(query_y, shown_y));
            default:    line_dirty = 1'b0;
        endcase
    end

    // R10: a clean frame start clears every dirty line
    a_r10_resync_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !pos_wr) |=> !line_dirty);

    // R9: a write never leaves a visible cursor's own first row clean
    a_r9_new_row_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        pos_wr |=> (!cur_vis || (query_y != cur_y) || line_dirty));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int SCREEN_W = 1024,
    parameter int CUR_DIM  = 16,
    parameter int PIX_W    = 8,
    parameter int X_BIAS   = 232,
    parameter int Y_BIAS   = 15,
    localparam int ADDR_W  = $clog2(2 * CUR_DIM + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [15:0]        cfg_data,
    input  logic               frame_start,
    input  logic               pix_valid,
    input  logic [12:0]        pix_x,
    input  logic [12:0]        pix_y,
    input  logic [PIX_W-1:0]   pix_idx,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_idx,
    input  logic [12:0]        query_y,
    output logic               line_dirty
);

    logic [CUR_DIM-1:0][CUR_DIM-1:0] plane_a;
    logic [CUR_DIM-1:0][CUR_DIM-1:0] plane_b;
    coord_t                          cur_x;
    coord_t                          cur_y;
    logic                            cur_vis;
    logic                            pos_wr;

    cursor_regs #(
        .CUR_DIM (CUR_DIM),
        .ADDR_W  (ADDR_W),
        .X_BIAS  (X_BIAS),
        .Y_BIAS  (Y_BIAS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .plane_a  (plane_a),
        .plane_b  (plane_b),
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .cur_vis  (cur_vis),
        .pos_wr   (pos_wr)
    );

    cursor_pixel #(
        .SCREEN_W (SCREEN_W),
        .CUR_DIM  (CUR_DIM),
        .PIX_W    (PIX_W)
    ) u_pixel (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_x     (coord_t'(pix_x)),
        .pix_y     (coord_t'(pix_y)),
        .pix_idx   (pix_idx),
        .cur_x     (cur_x),
        .cur_y     (cur_y),
        .cur_vis   (cur_vis),
        .plane_a   (plane_a),
        .plane_b   (plane_b),
        .out_valid (out_valid),
        .out_idx   (out_idx)
    );

    cursor_refresh #(
        .CUR_DIM (CUR_DIM)
    ) u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .pos_wr      (pos_wr),
        .frame_start (frame_start),
        .cur_y       (cur_y),
        .cur_vis     (cur_vis),
        .query_y     (coord_t'(query_y)),
        .line_dirty  (line_dirty)
    );

endmodule

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;

    localparam int W = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_data = '0;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [12:0] pix_x = '0;
    logic [12:0] pix_y = '0;
    logic [7:0]  pix_idx = '0;
    logic        out_valid;
    logic [7:0]  out_idx;
    logic [12:0] query_y = '0;
    logic        line_dirty;

    int total = 0;
    int bad = 0;
    int pa[16];
    int pb[16];
    int cx = -232;
    int cy = -15;
    int cvis = 0;
    int sy = 0;
    int svis = 0;

    always #2 clk = ~clk;

    cursor_overlay #(.SCREEN_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .frame_start(frame_start), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .pix_idx(pix_idx), .out_valid(out_valid),
        .out_idx(out_idx), .query_y(query_y), .line_dirty(line_dirty)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int x, input int y, input int idx);
        int c, r, a, b;
        if (cvis == 0) return idx;
        if (x < 0 || x >= W) return idx;
        c = x - cx;
        r = y - cy;
        if (c < 0 || c > 15 || r < 0 || r > 15) return idx;
        a = (pa[r] >> c) & 1;
        b = (pb[r] >> c) & 1;
        if (a == 1 && b == 1) return 255;
        if (a != b) return 254;
        return idx;
    endfunction

    function automatic int in_span(input int q, input int base);
        return (q >= base && q <= base + 15) ? 1 : 0;
    endfunction

    task automatic cfg_write(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 6'(addr);
        cfg_data = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int enc_x(input int x);
        int t, lo, fx;
        t = x + 232;
        lo = t & 3;
        fx = -(t - lo);
        return (fx & 'hFFC) | lo | 'hA000;
    endfunction

    function automatic int dec_x(input int v);
        int fx;
        fx = v & 'hFFC;
        if (fx >= 2048) fx = fx - 4096;
        return -fx + (v & 3) - 232;
    endfunction

    task automatic set_x_raw(input int v);
        cfg_write(32, v);
        cx = dec_x(v);
    endtask

    task automatic set_y(input int y);
        cfg_write(33, ((-(y + 15)) & 'hFFF) | 'h5000);
        cy = y;
    endtask

    task automatic set_vis(input int v);
        cfg_write(34, v | 'hFFFE * (v & 0));
        cvis = v & 1;
    endtask

    task automatic frame_pulse();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        sy = cy;
        svis = cvis;
    endtask

    task automatic load_planes(input int seed);
        for (int r = 0; r < 16; r++) begin
            pa[r] = ((r * 'h1357) ^ seed) & 'hFFFF;
            pb[r] = ((r * 'h02B1) + (seed >> 2)) & 'hFFFF;
            cfg_write(r, pa[r]);
            cfg_write(16 + r, pb[r]);
        end
    endtask

    // Streamed scan: one pixel per clock, each checked one clock later.
    task automatic sweep(input int ylo, input int yhi, input string tag);
        int pend, pexp;
        pend = 0;
        pexp = 0;
        for (int y = ylo; y <= yhi; y++) begin
            for (int x = -3; x <= W + 2; x++) begin
                @(negedge clk);
                if (pend == 1) check(tag, int'(out_idx), pexp);
                pix_valid = 1'b1;
                pix_x = 13'(x);
                pix_y = 13'(y);
                pix_idx = 8'((x * 5 + y * 11 + 3) & 255);
                pexp = model(x, y, (x * 5 + y * 11 + 3) & 255);
                pend = 1;
            end
        end
        @(negedge clk);
        check(tag, int'(out_idx), pexp);
        pix_valid = 1'b0;
    endtask

    task automatic dirty_scan(input string tag);
        for (int q = -20; q <= 70; q++) begin
            int e;
            query_y = 13'(q);
            #1;
            e = (cvis == 1 && in_span(q, cy) == 1) || (svis == 1 && in_span(q, sy) == 1);
            check(tag, int'(line_dirty), e);
        end
    endtask

    task automatic clean_scan(input string tag);
        for (int q = -20; q <= 70; q++) begin
            query_y = 13'(q);
            #1;
            check(tag, int'(line_dirty), 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 16; r++) begin pa[r] = 0; pb[r] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 out_valid", int'(out_valid), 0);
        clean_scan("R11 line_dirty");
        // R11: planes zero -> visible cursor is transparent
        set_x_raw(enc_x(5));
        set_y(5);
        set_vis(1);
        sweep(3, 22, "R11 planes zero");

        // R3 R4: main pattern sweeps at several positions
        load_planes('h0F0F);
        sweep(3, 22, "R3 R4 pattern at 5,5");
        set_x_raw(enc_x(30));
        set_y(-4);
        sweep(-6, 13, "R1 R2 R4 y partly above");
        load_planes('hC3A5);
        // R6: partly off the left and right edges
        set_x_raw(enc_x(-7));
        set_y(20);
        sweep(19, 36, "R6 left clip");
        set_x_raw(enc_x(W - 5));
        sweep(19, 36, "R6 right clip");

        // R1: raw encodings with non-negated low bits and garbage high bits
        for (int v = 'hF00; v <= 'hF40; v += 5) begin
            set_x_raw(v | 'h3000);
            sweep(25, 25, "R1 raw decode");
        end

        // R5: hidden cursor
        set_x_raw(enc_x(12));
        set_y(8);
        set_vis(0);
        sweep(6, 25, "R5 hidden");

        // R8: write takes effect for the very next pixel
        pa[0] = 'hFFFF;
        pb[0] = 'hFFFF;
        cfg_write(0, 'hFFFF);
        cfg_write(16, 'hFFFF);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'd34; cfg_data = 16'h0001;
        @(negedge clk);
        cfg_we = 1'b0;
        cvis = 1;
        pix_valid = 1'b1; pix_x = 13'd12; pix_y = 13'd8; pix_idx = 8'd7;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R8 next-pixel effect", int'(out_idx), 255);
        // R7: valid follows one cycle later
        check("R7 valid high", int'(out_valid), 1);
        @(negedge clk);
        check("R7 valid low", int'(out_valid), 0);

        // R9 R10: refresh tracking
        set_y(10);
        frame_pulse();
        clean_scan("R10 after frame start");
        set_y(30);
        dirty_scan("R9 y move");
        frame_pulse();
        clean_scan("R10 after move");
        set_vis(0);
        dirty_scan("R9 hide");
        frame_pulse();
        set_vis(1);
        dirty_scan("R9 show");
        frame_pulse();
        set_x_raw(enc_x(40));
        dirty_scan("R9 x move");
        frame_pulse();

        // R12: unused addresses change nothing
        for (int a = 35; a < 64; a++) cfg_write(a, 'hFFFF);
        clean_scan("R12 no dirty");
        sweep(28, 47, "R12 drawing unchanged");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule